// File: doc/BRIEF.md
# Reset Sequencer with Start-up Timers

This block merges every reset request of a small processor into a single chip reset, then keeps that reset asserted until the clocks can be trusted. A power-on event starts a slow power-up delay, counted in ticks of the internal low-speed oscillator. When that delay ends, an oscillator settling delay follows, counted in cycles of the main clock. Every other request skips both delays. Once the request has gone away, the reset drops after a short settling wait.

The external reset pin is active low. It passes through a two-flop synchronizer and a glitch filter that samples on the slow tick. A configuration bit can disable the pin entirely. A second enable bit gates brown-out detection. The block records the cause of the most recent reset as a 3-bit code. It also keeps five active-low status flags that firmware reads after start-up, and firmware can re-arm two of them with write-one strobes.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_pulse` is high, `chip_rst` is 1. After `por_pulse` falls, `chip_rst` stays 1 until both of these have elapsed, in order:
  - 2^PWRT_W slow ticks;
  - then 2^OST_W clock cycles.
  It then falls within a few cycles.
- R2: A power-on sets `flag_por_n`=0 and `flag_bor_n`=0, sets `flag_ri_n`, `flag_to_n` and `flag_pd_n` to 1, and sets `cause`=0.
- R3: A watchdog time-out, reset instruction, stack-full flag, stack-underflow flag, enabled brown-out or filtered pin request sets `chip_rst` at the next clock edge. Neither start-up timer runs. For a one-cycle request, `chip_rst` stays high for exactly SYNC_CYC+1 cycles.
- R4: The pin requests a reset only after it has been sampled low on FILT_N consecutive slow ticks. A shorter low pulse leaves `chip_rst` at 0.
- R5: With `ext_en`=0, a low pin leaves `chip_rst` and `cause` unchanged.
- R6: With `bor_en`=0, `bor_det` changes neither `chip_rst` nor `flag_bor_n`.
- R7: `cause` holds the code of the last request, as follows:
  - 0: power-on
  - 1: pin while running
  - 2: pin while `in_sleep`=1
  - 3: watchdog
  - 4: brown-out
  - 5: reset instruction
  - 6: stack full
  - 7: stack underflow
- R8: When requests coincide, the recorded cause follows this priority, highest first: brown-out, watchdog, pin, instruction, stack full, stack underflow.
- R9: Each cause updates the flags as follows:
  - watchdog clears `flag_to_n`;
  - instruction clears `flag_ri_n`;
  - pin during sleep clears `flag_pd_n`;
  - brown-out clears `flag_bor_n` and sets `flag_ri_n`, `flag_to_n` and `flag_pd_n` to 1.
- R10: A one-cycle `rearm_por` or `rearm_bor` strobe sets the matching flag to 1. If a brown-out occurs in the same cycle as `rearm_bor`, the event wins and `flag_bor_n` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | main oscillator clock |
| por_pulse | input | 1 | power-on pulse, synchronous, active high |
| ext_rst_n | input | 1 | external reset pin, active low, asynchronous |
| ext_en | input | 1 | configuration enable for the pin |
| bor_det | input | 1 | brown-out detector output |
| bor_en | input | 1 | brown-out reset enable |
| wdt_timeout | input | 1 | watchdog time-out strobe |
| reset_instr | input | 1 | reset instruction strobe |
| stk_full | input | 1 | return stack overflow |
| stk_under | input | 1 | return stack underflow |
| in_sleep | input | 1 | core is in sleep or idle |
| slow_tick | input | 1 | one-cycle pulse per internal slow-oscillator period |
| rearm_por | input | 1 | firmware write-one to the power-on flag |
| rearm_bor | input | 1 | firmware write-one to the brown-out flag |
| chip_rst | output | 1 | chip reset, active high, registered |
| cause | output | 3 | code of the last reset cause |
| flag_ri_n | output | 1 | low after a reset instruction |
| flag_to_n | output | 1 | low after a watchdog time-out |
| flag_pd_n | output | 1 | low after a pin reset in sleep |
| flag_por_n | output | 1 | low after power-on |
| flag_bor_n | output | 1 | low after brown-out or power-on |

## Verification
The assertions assume that every input except `ext_rst_n` is synchronous to `clk`. They also assume that `slow_tick` is a one-cycle pulse and that `por_pulse` acts as the reset under which they are disabled. The bench drives all inputs on the falling edge and generates `slow_tick` from a divider in the same clock domain. It uses small timer widths so that the whole power-on sequence fits in a short run. The pin is moved only on falling edges and held for many cycles, so the synchronizer never sees a change near a sampling edge.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [2:0] {
    CAUSE_POR       = 3'd0,
    CAUSE_EXT_RUN   = 3'd1,
    CAUSE_EXT_SLEEP = 3'd2,
    CAUSE_WDT       = 3'd3,
    CAUSE_BOR       = 3'd4,
    CAUSE_INSTR     = 3'd5,
    CAUSE_STK_FULL  = 3'd6,
    CAUSE_STK_UNDER = 3'd7
  } cause_e;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_HOLD,
    ST_SETTLE,
    ST_PWRUP,
    ST_OSCWAIT
  } seq_state_e;
endpackage

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
  parameter int unsigned SAMPLES = 4
) (
  input  logic clk,
  input  logic srst,
  input  logic tick,
  input  logic pin_n,
  output logic low_ok
);
  localparam int unsigned CW = $clog2(SAMPLES + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      sync_q <= 2'b11;
      run_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_n};
      if (tick) begin
        if (sync_q[1])
          run_q <= '0;
        else if (run_q != CW'(SAMPLES))
          run_q <= run_q + 1'b1;
      end
    end
  end

  assign low_ok = (run_q == CW'(SAMPLES));
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int unsigned W = 10
) (
  input  logic clk,
  input  logic clr,
  input  logic step,
  output logic done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (step && !done) begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) done <= 1'b1;
    end
  end
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int unsigned PWRT_W   = 11,
  parameter int unsigned OST_W    = 10,
  parameter int unsigned FILT_N   = 4,
  parameter int unsigned SYNC_CYC = 2
) (
  input  logic       clk,
  input  logic       por_pulse,
  input  logic       ext_rst_n,
  input  logic       ext_en,
  input  logic       bor_det,
  input  logic       bor_en,
  input  logic       wdt_timeout,
  input  logic       reset_instr,
  input  logic       stk_full,
  input  logic       stk_under,
  input  logic       in_sleep,
  input  logic       slow_tick,
  input  logic       rearm_por,
  input  logic       rearm_bor,
  output logic       chip_rst,
  output logic [2:0] cause,
  output logic       flag_ri_n,
  output logic       flag_to_n,
  output logic       flag_pd_n,
  output logic       flag_por_n,
  output logic       flag_bor_n
);
  localparam int unsigned SW = $clog2(SYNC_CYC + 1);

  seq_state_e    state_q, state_d;
  logic [SW-1:0] settle_q;
  logic          ext_low, ext_req, bor_req, any_req;
  logic          pwrt_done, ost_done;
  cause_e        hit;

  rstseq_pin_filter #(.SAMPLES(FILT_N)) u_filt (
    .clk(clk), .srst(por_pulse), .tick(slow_tick),
    .pin_n(ext_rst_n), .low_ok(ext_low)
  );

  rstseq_timer #(.W(PWRT_W)) u_pwrt (
    .clk(clk), .clr(por_pulse || state_q != ST_PWRUP),
    .step(slow_tick), .done(pwrt_done)
  );

  rstseq_timer #(.W(OST_W)) u_ost (
    .clk(clk), .clr(por_pulse || state_q != ST_OSCWAIT),
    .step(1'b1), .done(ost_done)
  );

  assign ext_req = ext_low && ext_en;
  assign bor_req = bor_det && bor_en;
  assign any_req = ext_req || bor_req || wdt_timeout || reset_instr ||
                   stk_full || stk_under;

  always_comb begin
    if (bor_req)          hit = CAUSE_BOR;
    else if (wdt_timeout) hit = CAUSE_WDT;
    else if (ext_req)     hit = in_sleep ? CAUSE_EXT_SLEEP : CAUSE_EXT_RUN;
    else if (reset_instr) hit = CAUSE_INSTR;
    else if (stk_full)    hit = CAUSE_STK_FULL;
    else                  hit = CAUSE_STK_UNDER;
  end

  always_comb begin
    state_d = state_q;
    if (any_req) begin
      state_d = ST_HOLD;
    end else begin
      case (state_q)
        ST_HOLD:    state_d = ST_SETTLE;
        ST_SETTLE:  if (settle_q == SW'(SYNC_CYC - 1)) state_d = ST_RUN;
        ST_PWRUP:   if (pwrt_done) state_d = ST_OSCWAIT;
        ST_OSCWAIT: if (ost_done) state_d = ST_RUN;
        default:    state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (por_pulse) begin
      state_q    <= ST_PWRUP;
      settle_q   <= '0;
      chip_rst   <= 1'b1;
      cause      <= CAUSE_POR;
      flag_ri_n  <= 1'b1;
      flag_to_n  <= 1'b1;
      flag_pd_n  <= 1'b1;
      flag_por_n <= 1'b0;
      flag_bor_n <= 1'b0;
    end else begin
      state_q  <= state_d;
      chip_rst <= (state_d != ST_RUN);
      settle_q <= (state_q == ST_SETTLE) ? settle_q + 1'b1 : '0;
      if (rearm_por) flag_por_n <= 1'b1;
      if (rearm_bor) flag_bor_n <= 1'b1;
      if (any_req) begin
        cause <= hit;
        case (hit)
          CAUSE_BOR: begin
            flag_bor_n <= 1'b0;
            flag_ri_n  <= 1'b1;
            flag_to_n  <= 1'b1;
            flag_pd_n  <= 1'b1;
          end
          CAUSE_WDT:       flag_to_n <= 1'b0;
          CAUSE_EXT_SLEEP: flag_pd_n <= 1'b0;
          CAUSE_INSTR:     flag_ri_n <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/reset_sequencer_chk.sv
module reset_sequencer_chk (
  input logic       clk,
  input logic       por_pulse,
  input logic       ext_en,
  input logic       bor_det,
  input logic       bor_en,
  input logic       wdt_timeout,
  input logic       reset_instr,
  input logic       stk_full,
  input logic       stk_under,
  input logic       rearm_por,
  input logic       rearm_bor,
  input logic       chip_rst,
  input logic [2:0] cause,
  input logic       flag_to_n,
  input logic       flag_por_n,
  input logic       flag_bor_n
);
  logic port_req;
  assign port_req = wdt_timeout || reset_instr || stk_full || stk_under ||
                    (bor_det && bor_en);

  a_r3_source_sets_reset: assert property (@(posedge clk) disable iff (por_pulse)
    port_req |=> chip_rst);

  a_r3_release_when_quiet: assert property (@(posedge clk) disable iff (por_pulse)
    $fell(chip_rst) |-> $past(!port_req));

  a_r5_pin_disabled_quiet: assert property (@(posedge clk) disable iff (por_pulse)
    (!chip_rst && !ext_en && !port_req) |=> !chip_rst);

  a_r6_bor_flag_held: assert property (@(posedge clk) disable iff (por_pulse)
    (!bor_en && !rearm_bor) |=> $stable(flag_bor_n));

  a_r7_wdt_cause: assert property (@(posedge clk) disable iff (por_pulse)
    (wdt_timeout && !(bor_det && bor_en)) |=> (cause == 3'd3));

  a_r9_wdt_flag: assert property (@(posedge clk) disable iff (por_pulse)
    (wdt_timeout && !(bor_det && bor_en)) |=> !flag_to_n);

  a_r10_rearm_por: assert property (@(posedge clk) disable iff (por_pulse)
    rearm_por |=> flag_por_n);
endmodule

bind reset_sequencer reset_sequencer_chk u_chk (
  .clk(clk), .por_pulse(por_pulse), .ext_en(ext_en), .bor_det(bor_det),
  .bor_en(bor_en), .wdt_timeout(wdt_timeout), .reset_instr(reset_instr),
  .stk_full(stk_full), .stk_under(stk_under), .rearm_por(rearm_por),
  .rearm_bor(rearm_bor), .chip_rst(chip_rst), .cause(cause),
  .flag_to_n(flag_to_n), .flag_por_n(flag_por_n), .flag_bor_n(flag_bor_n)
);

// File: tb/reset_sequencer_test.sv
`timescale 1ns/1ps
module reset_sequencer_test;
  localparam int PWRT_W = 3;
  localparam int OST_W = 4;
  localparam int FILT_N = 4;
  localparam int SYNC_CYC = 2;
  localparam int TICK_DIV = 8;

  logic clk = 1'b0;
  logic por_pulse = 1'b1, ext_rst_n = 1'b1, ext_en = 1'b1;
  logic bor_det = 1'b0, bor_en = 1'b1, wdt_timeout = 1'b0, reset_instr = 1'b0;
  logic stk_full = 1'b0, stk_under = 1'b0, in_sleep = 1'b0, slow_tick = 1'b0;
  logic rearm_por = 1'b0, rearm_bor = 1'b0;
  logic chip_rst, flag_ri_n, flag_to_n, flag_pd_n, flag_por_n, flag_bor_n;
  logic [2:0] cause;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  reset_sequencer #(.PWRT_W(PWRT_W), .OST_W(OST_W), .FILT_N(FILT_N),
                    .SYNC_CYC(SYNC_CYC)) uut (
    .clk(clk), .por_pulse(por_pulse), .ext_rst_n(ext_rst_n), .ext_en(ext_en),
    .bor_det(bor_det), .bor_en(bor_en), .wdt_timeout(wdt_timeout),
    .reset_instr(reset_instr), .stk_full(stk_full), .stk_under(stk_under),
    .in_sleep(in_sleep), .slow_tick(slow_tick), .rearm_por(rearm_por),
    .rearm_bor(rearm_bor), .chip_rst(chip_rst), .cause(cause),
    .flag_ri_n(flag_ri_n), .flag_to_n(flag_to_n), .flag_pd_n(flag_pd_n),
    .flag_por_n(flag_por_n), .flag_bor_n(flag_bor_n)
  );

  always #4 clk = ~clk;

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      div = (div + 1) % TICK_DIV;
      slow_tick = (div == TICK_DIV - 1);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drives a one-cycle request {bor, under, full, instr, wdt}; returns reset length
  task automatic pulse(input logic [4:0] m, output int n);
    @(negedge clk);
    {bor_det, stk_under, stk_full, reset_instr, wdt_timeout} = m;
    @(negedge clk);
    {bor_det, stk_under, stk_full, reset_instr, wdt_timeout} = '0;
    n = 0;
    while (chip_rst && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_power_on;
    int n = 0;
    int lo = ((1 << PWRT_W) - 1) * TICK_DIV + (1 << OST_W);
    int hi = (1 << PWRT_W) * TICK_DIV + (1 << OST_W) + 8;
    repeat (3) @(negedge clk);
    check("R1 reset during por", chip_rst, 1);
    check("R2 por flag", flag_por_n, 0);
    check("R2 bor flag", flag_bor_n, 0);
    check("R2 ri/to/pd", {flag_ri_n, flag_to_n, flag_pd_n}, 3'b111);
    check("R2 cause", cause, 0);
    por_pulse = 1'b0;
    while (chip_rst && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check("R1 release not early", int'(n >= lo), 1);
    check("R1 release not late", int'(n <= hi), 1);
  endtask

  task automatic t_wdt;
    int n;
    pulse(5'b00001, n);
    check("R3 wdt length", n, SYNC_CYC + 1);
    check("R7 wdt cause", cause, 3);
    check("R9 wdt to flag", flag_to_n, 0);
    check("R9 wdt pd flag", flag_pd_n, 1);
  endtask

  task automatic t_priority;
    int n;
    pulse(5'b00111, n);
    check("R8 wdt over instr/stack", cause, 3);
    check("R8 ri flag untouched", flag_ri_n, 1);
  endtask

  task automatic t_instr_stack;
    int n;
    pulse(5'b00010, n);
    check("R3 instr length", n, SYNC_CYC + 1);
    check("R7 instr cause", cause, 5);
    check("R9 instr ri flag", flag_ri_n, 0);
    pulse(5'b00100, n);
    check("R3 stack full length", n, SYNC_CYC + 1);
    check("R7 stack full cause", cause, 6);
    pulse(5'b01000, n);
    check("R3 stack under length", n, SYNC_CYC + 1);
    check("R7 stack under cause", cause, 7);
  endtask

  task automatic t_rearm;
    @(negedge clk);
    rearm_por = 1'b1;
    rearm_bor = 1'b1;
    @(negedge clk);
    rearm_por = 1'b0;
    rearm_bor = 1'b0;
    check("R10 por rearm", flag_por_n, 1);
    check("R10 bor rearm", flag_bor_n, 1);
  endtask

  task automatic t_bor;
    int n;
    int seen = 0;
    bor_en = 1'b0;
    @(negedge clk);
    bor_det = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (chip_rst) seen++;
    end
    bor_det = 1'b0;
    @(negedge clk);
    check("R6 bor disabled no reset", seen, 0);
    check("R6 bor disabled flag", flag_bor_n, 1);
    bor_en = 1'b1;
    pulse(5'b10001, n);
    check("R3 bor length", n, SYNC_CYC + 1);
    check("R8 bor over wdt", cause, 4);
    check("R9 bor flags", {flag_bor_n, flag_ri_n, flag_to_n, flag_pd_n}, 4'b0111);
    check("R9 por flag kept", flag_por_n, 1);
    t_rearm();
    @(negedge clk);
    bor_det = 1'b1;
    rearm_bor = 1'b1;
    @(negedge clk);
    bor_det = 1'b0;
    rearm_bor = 1'b0;
    check("R10 event beats rearm", flag_bor_n, 0);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_pin(input logic sleep, input int exp_cause);
    in_sleep = sleep;
    @(negedge clk);
    ext_rst_n = 1'b0;
    repeat (60) @(negedge clk);
    check("R4 pin held low resets", chip_rst, 1);
    ext_rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check("R4 pin release", chip_rst, 0);
    check("R7 pin cause", cause, exp_cause);
    if (sleep) check("R9 sleep pd flag", flag_pd_n, 0);
    in_sleep = 1'b0;
  endtask

  task automatic t_glitch;
    int seen = 0;
    logic [2:0] c0 = cause;
    @(negedge clk);
    ext_rst_n = 1'b0;
    repeat (12) begin
      @(negedge clk);
      if (chip_rst) seen++;
    end
    ext_rst_n = 1'b1;
    repeat (48) begin
      @(negedge clk);
      if (chip_rst) seen++;
    end
    check("R4 short low ignored", seen, 0);
    check("R4 cause unchanged", cause, c0);
  endtask

  task automatic t_pin_disabled;
    int seen = 0;
    logic [2:0] c0 = cause;
    ext_en = 1'b0;
    @(negedge clk);
    ext_rst_n = 1'b0;
    repeat (60) begin
      @(negedge clk);
      if (chip_rst) seen++;
    end
    ext_rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check("R5 disabled pin no reset", seen, 0);
    check("R5 disabled pin cause", cause, c0);
    ext_en = 1'b1;
  endtask

  initial begin
    t_power_on();
    t_wdt();
    t_priority();
    t_instr_stack();
    t_rearm();
    t_bor();
    t_pin(1'b0, 1);
    t_pin(1'b1, 2);
    t_glitch();
    t_pin_disabled();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule